// File: doc/BRIEF.md
# Synchronous Master Serial Transmitter

This block sends parallel words as a clocked serial stream. It owns both lines: it generates the shift clock and it drives the data line. Software writes a word into a holding register. The block moves that word into an internal shift register that software cannot see, so the next word can be queued while the current one is still going out. The move happens only after the previous frame's last bit has left. A flag reports that the holding register is empty. ANDed with its enable, this flag forms the interrupt request. A separate status output reports that the shift register is idle.

A frame is eight data bits, sent least-significant bit first. An optional ninth bit can follow them. It comes from a dedicated input that is captured when the holding register is written. The shift clock is the system clock divided by four times (divider + 1). It toggles only while a frame is shifting and idles low. Data changes while the clock is low, so a receiver can sample on the rising edge. The link is half-duplex: a receive-inhibit output is held high while a frame shifts.

Top module: `sync_tx_master`

## Requirements
- R1: After reset, `hold_empty` and `shift_empty` read 1, `ser_clk` reads 0 and `irq` reads 0 while `irq_en` is 0.
- R2: A write (`wr_en` high for one cycle) makes `hold_empty` read 0 from the next clock edge onward.
- R3: While the port is master-active and `tx_en` is 1, a full holding register and an idle shift register lead to a load at the next edge. From then on `hold_empty` reads 1 and `shift_empty` reads 0.
- R4: `irq` is 1 exactly when `hold_empty` is 1 and `irq_en` is 1.
- R5: Once `hold_empty` is 1, it stays 1 until the next write, whatever happens on the other inputs.
- R6: Data bits leave least-significant bit first. `ser_dat` holds steady while `ser_clk` is high and changes only while the clock is low.
- R7: `ser_clk` is low whenever no frame is shifting. During a frame its period is 4*(`div_val`+1) system clocks, using the `div_val` captured at load.
- R8: With `nine_bit_mode` at 1 when the frame loads, a frame has 9 clock pulses. The ninth bit is the value `ninth_bit` had at the write. Otherwise a frame has 8 pulses.
- R9: A word written while a frame is shifting loads on the first edge after that frame ends. Between the two frames `shift_empty` reads 1 for one cycle only.
- R10: Unless `mode_sync`, `port_en` and `clk_master` are all 1, no load occurs, any frame in progress stops, and `ser_dat_oe` is 0.
- R11: `rx_inhibit` is 1 exactly while a frame is shifting, that is, while `shift_empty` is 0.
- R12: Clearing `tx_en` mid-frame stops the frame at the next edge, with `shift_empty` back to 1 and `ser_clk` low. A word waiting in the holding register is kept and goes out once `tx_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sync | input | 1 | Synchronous-mode select |
| port_en | input | 1 | Serial port enable |
| clk_master | input | 1 | Clock-source select (1 = this block drives the clock) |
| tx_en | input | 1 | Transmit enable |
| nine_bit_mode | input | 1 | Selects 9-bit frames, sampled at load |
| ninth_bit | input | 1 | Ninth data bit, captured with each write |
| div_val | input | DIV_W | Baud divider value |
| irq_en | input | 1 | Interrupt enable for the holding-empty flag |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | DATA_W | Holding-register write data |
| hold_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register idle status |
| ser_clk | output | 1 | Generated shift clock |
| ser_dat | output | 1 | Serial data |
| ser_dat_oe | output | 1 | Output enable for the data line |
| rx_inhibit | output | 1 | Receive inhibit while transmitting |

## Verification
After a write strobe, `hold_empty` falls one edge later. The load follows one edge after that, so `hold_empty` rises and `shift_empty` falls two edges after the strobe. The bench samples on the falling system-clock edge at exactly those points. During a frame, the bench watches every falling-edge sample for a rising `ser_clk`. It takes the bit there, measures the gap between rises against 4*(`div_val`+1), and flags any change in data while the clock is high. After a frame ends, the follow-on load is checked one edge later. After an abort, `shift_empty` and the clock are checked one edge later.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } sclk_phase_e;

   function automatic int frame_bits(input int data_w, input bit nine);
      return nine ? data_w + 1 : data_w;
   endfunction
endpackage

// File: rtl/sync_tx_baud.sv
module sync_tx_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] lim_q;
   logic [CW-1:0] cnt_q;

   // half period = 2*(div+1) system clocks, so the limit is {div,1}
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= '0;
      end else if (load) begin
         lim_q <= {div_val, 1'b1};
      end
   end

   assign tick = run && (cnt_q == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load || !run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sync_tx_hold.sv
module sync_tx_hold #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_word,
   input  logic         take,
   output logic         full,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
      end else if (wr_en) begin
         full <= 1'b1;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= wr_word;
      end
   end
endmodule

// File: rtl/sync_tx_shift.sv
module sync_tx_shift
   import sync_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit NINE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          load,
   input  logic [DATA_W:0] load_word,
   input  logic          nine,
   input  logic          tick,
   output logic          busy,
   output logic          sclk,
   output logic          sdat
);
   localparam int FW = DATA_W + 1;
   localparam int IW = $clog2(FW + 1);
   localparam logic [IW-1:0] LAST_SHORT = IW'(frame_bits(DATA_W, 1'b0) - 1);
   localparam logic [IW-1:0] LAST_LONG  = IW'(frame_bits(DATA_W, 1'b1) - 1);

   logic [FW-1:0]  sreg_q;
   logic [IW-1:0]  idx_q;
   logic [IW-1:0]  last_q;
   logic [IW-1:0]  last_sel;
   sclk_phase_e    ph_q;

   generate
      if (NINE_EN) begin : g_nine
         assign last_sel = nine ? LAST_LONG : LAST_SHORT;
      end else begin : g_eight
         logic unused_nine;
         assign unused_nine = nine;
         assign last_sel = LAST_SHORT;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         ph_q   <= PH_LOW;
         idx_q  <= '0;
         last_q <= '0;
         sreg_q <= '0;
      end else if (!enable) begin
         busy <= 1'b0;
         ph_q <= PH_LOW;
      end else if (load) begin
         busy   <= 1'b1;
         ph_q   <= PH_LOW;
         idx_q  <= '0;
         last_q <= last_sel;
         sreg_q <= load_word;
      end else if (busy && tick) begin
         if (ph_q == PH_LOW) begin
            ph_q <= PH_HIGH;
         end else begin
            ph_q <= PH_LOW;
            if (idx_q == last_q) begin
               busy <= 1'b0;
            end else begin
               idx_q  <= idx_q + 1'b1;
               sreg_q <= {1'b0, sreg_q[FW-1:1]};
            end
         end
      end
   end

   assign sclk = busy && (ph_q == PH_HIGH);
   assign sdat = busy && sreg_q[0];
endmodule

// File: rtl/sync_tx_master.sv
module sync_tx_master #(
   parameter int DATA_W  = 8,
   parameter int DIV_W   = 8,
   parameter bit NINE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_sync,
   input  logic              port_en,
   input  logic              clk_master,
   input  logic              tx_en,
   input  logic              nine_bit_mode,
   input  logic              ninth_bit,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              irq_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hold_empty,
   output logic              irq,
   output logic              shift_empty,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              ser_dat_oe,
   output logic              rx_inhibit
);
   localparam int HW = DATA_W + 1;

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("sync_tx_master: DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("sync_tx_master: DIV_W must be at least 1");
      end
   endgenerate

   logic          active;
   logic          go;
   logic          busy;
   logic          hold_full;
   logic          load;
   logic          tick;
   logic [HW-1:0] wr_word;
   logic [HW-1:0] hold_q;

   assign active = mode_sync && port_en && clk_master;
   assign go     = active && tx_en;
   assign load   = go && !busy && hold_full;

   generate
      if (NINE_EN) begin : g_word9
         assign wr_word = {ninth_bit, wr_data};
      end else begin : g_word8
         logic unused_ninth;
         assign unused_ninth = ninth_bit;
         assign wr_word = {1'b0, wr_data};
      end
   endgenerate

   sync_tx_hold #(.W(HW)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_word (wr_word),
      .take    (load),
      .full    (hold_full),
      .q       (hold_q)
   );

   sync_tx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .load    (load),
      .div_val (div_val),
      .tick    (tick)
   );

   sync_tx_shift #(.DATA_W(DATA_W), .NINE_EN(NINE_EN)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (go),
      .load      (load),
      .load_word (hold_q),
      .nine      (nine_bit_mode),
      .tick      (tick),
      .busy      (busy),
      .sclk      (ser_clk),
      .sdat      (ser_dat)
   );

   assign hold_empty  = !hold_full;
   assign irq         = hold_empty && irq_en;
   assign shift_empty = !busy;
   assign ser_dat_oe  = active;
   assign rx_inhibit  = busy;
endmodule

// File: rtl/sync_tx_master_chk.sv
module sync_tx_master_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_sync,
   input logic port_en,
   input logic clk_master,
   input logic tx_en,
   input logic wr_en,
   input logic hold_empty,
   input logic shift_empty,
   input logic ser_clk,
   input logic ser_dat
);
   // R1: leaving reset both registers read empty
   p_reset_empty_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (hold_empty && shift_empty && !ser_clk));

   // R2
   p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !hold_empty);

   // R3: holding only empties through a load into the shifter
   p_load_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_empty) |-> !shift_empty);

   // R5
   p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_empty && !wr_en) |=> hold_empty);

   // R6
   p_data_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

   // R7
   p_clock_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty |-> !ser_clk);

   // R10
   p_inactive_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_sync && port_en && clk_master) |=> shift_empty);

   // R12
   p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (shift_empty && !ser_clk));
endmodule

bind sync_tx_master sync_tx_master_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_sync   (mode_sync),
   .port_en     (port_en),
   .clk_master  (clk_master),
   .tx_en       (tx_en),
   .wr_en       (wr_en),
   .hold_empty  (hold_empty),
   .shift_empty (shift_empty),
   .ser_clk     (ser_clk),
   .ser_dat     (ser_dat)
);

// File: tb/tb_sync_tx_master.sv
module tb_sync_tx_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_sync = 1'b0, port_en = 1'b0, clk_master = 1'b0, tx_en = 1'b0;
   logic       nine_bit_mode = 1'b0, ninth_bit = 1'b0, irq_en = 1'b0, wr_en = 1'b0;
   logic [7:0] div_val = '0;
   logic [7:0] wr_data = '0;
   logic       hold_empty, irq, shift_empty, ser_clk, ser_dat, ser_dat_oe, rx_inhibit;

   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   sync_tx_master dut (
      .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .port_en(port_en),
      .clk_master(clk_master), .tx_en(tx_en), .nine_bit_mode(nine_bit_mode),
      .ninth_bit(ninth_bit), .div_val(div_val), .irq_en(irq_en), .wr_en(wr_en),
      .wr_data(wr_data), .hold_empty(hold_empty), .irq(irq),
      .shift_empty(shift_empty), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_dat_oe(ser_dat_oe), .rx_inhibit(rx_inhibit)
   );

   // {nine, ninth, div[3:0], data[7:0]}
   localparam logic [13:0] VEC [6] = '{
      {1'b0, 1'b0, 4'd0, 8'hA5},
      {1'b0, 1'b0, 4'd1, 8'h01},
      {1'b1, 1'b1, 4'd2, 8'h80},
      {1'b1, 1'b0, 4'd0, 8'hFF},
      {1'b0, 1'b0, 4'd3, 8'h3C},
      {1'b1, 1'b1, 4'd1, 8'h00}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write_word(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // sample every falling system edge until the shifter goes idle
   task automatic capture(output logic [8:0] bits, output int nbits,
                          output int period_bad, input int exp_period,
                          output int steady_bad, output int inh_bad);
      logic prev_clk = 1'b0;
      logic prev_dat = 1'b0;
      int   cyc = 0;
      int   last_rise = -1;
      bits = '0;
      nbits = 0;
      period_bad = 0;
      steady_bad = 0;
      inh_bad = 0;
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         cyc++;
         if (rx_inhibit != !shift_empty) inh_bad++;
         if (ser_clk && !prev_clk) begin
            if (nbits < 9) bits[nbits] = ser_dat;
            if (last_rise >= 0 && (cyc - last_rise) != exp_period) period_bad++;
            last_rise = cyc;
            nbits++;
         end
         if (ser_clk && prev_clk && ser_dat != prev_dat) steady_bad++;
         prev_clk = ser_clk;
         prev_dat = ser_dat;
         if (shift_empty) break;
      end
   endtask

   task automatic check_frame(input logic [8:0] exp_bits, input int exp_n, input int per);
      logic [8:0] got;
      int n, pb, sb, ib;
      capture(got, n, pb, per, sb, ib);
      chk(n == exp_n, "R8 pulse count", n, exp_n);
      chk((got & ((9'd1 << exp_n) - 1)) == exp_bits, "R6/R8 bits LSB first",
          int'(got), int'(exp_bits));
      chk(pb == 0, "R7 clock period", pb, 0);
      chk(sb == 0, "R6 data steady while clock high", sb, 0);
      chk(ib == 0, "R11 rx_inhibit tracks shifting", ib, 0);
      chk(ser_clk == 1'b0, "R7 clock idles low", int'(ser_clk), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [13:0] v;
      int per;

      // R1 reset state
      do_reset();
      chk(hold_empty == 1'b1, "R1 hold_empty", int'(hold_empty), 1);
      chk(shift_empty == 1'b1, "R1 shift_empty", int'(shift_empty), 1);
      chk(ser_clk == 1'b0, "R1 ser_clk", int'(ser_clk), 0);
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq == 1'b1, "R4 irq with enable", int'(irq), 1);

      // table of frames
      mode_sync = 1'b1; port_en = 1'b1; clk_master = 1'b1; tx_en = 1'b1;
      for (int i = 0; i < 6; i++) begin
         v = VEC[i];
         nine_bit_mode = v[13];
         ninth_bit = v[12];
         div_val = {4'd0, v[11:8]};
         per = 4 * (int'(v[11:8]) + 1);
         write_word(v[7:0]);
         chk(hold_empty == 1'b0, "R2 hold filled", int'(hold_empty), 0);
         chk(irq == 1'b0, "R4 irq low when full", int'(irq), 0);
         @(negedge clk);
         chk(hold_empty && !shift_empty, "R3 load", int'({hold_empty, shift_empty}), 2);
         chk(irq == 1'b1, "R4 irq after load", int'(irq), 1);
         check_frame({v[12], v[7:0]}, v[13] ? 9 : 8, per);
      end

      // R5 flag sticky without a write
      irq_en = 1'b0;
      tx_en = 1'b0;
      repeat (20) @(negedge clk);
      irq_en = 1'b1;
      tx_en = 1'b1;
      repeat (10) @(negedge clk);
      chk(hold_empty == 1'b1, "R5 flag stays set", int'(hold_empty), 1);

      // R9 double buffering
      nine_bit_mode = 1'b0;
      div_val = 8'd1;
      write_word(8'h5A);
      @(negedge clk);
      write_word(8'hC3);
      chk(hold_empty == 1'b0 && shift_empty == 1'b0, "R9 queued during frame",
          int'({hold_empty, shift_empty}), 0);
      check_frame(9'h05A, 8, 8);
      @(negedge clk);
      chk(shift_empty == 1'b0 && hold_empty == 1'b1, "R9 reload one edge after end",
          int'({hold_empty, shift_empty}), 2);
      check_frame(9'h0C3, 8, 8);

      // R12 abort mid-frame keeps queued word
      write_word(8'h96);
      @(negedge clk);
      write_word(8'h69);
      repeat (7) @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk(shift_empty == 1'b1 && ser_clk == 1'b0, "R12 abort stops frame",
          int'({shift_empty, ser_clk}), 2);
      repeat (10) @(negedge clk);
      chk(hold_empty == 1'b0, "R12 queued word kept", int'(hold_empty), 0);
      tx_en = 1'b1;
      @(negedge clk);
      chk(shift_empty == 1'b0, "R12 resumes on enable", int'(shift_empty), 0);
      check_frame(9'h069, 8, 8);

      // R10 inactive configuration
      clk_master = 1'b0;
      @(negedge clk);
      chk(ser_dat_oe == 1'b0, "R10 output disabled", int'(ser_dat_oe), 0);
      write_word(8'h33);
      repeat (20) @(negedge clk);
      chk(hold_empty == 1'b0 && shift_empty == 1'b1, "R10 no load when inactive",
          int'({hold_empty, shift_empty}), 1);
      chk(ser_clk == 1'b0, "R10 clock quiet", int'(ser_clk), 0);
      clk_master = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(shift_empty == 1'b0 && ser_dat_oe == 1'b1, "R10 loads once active",
          int'({shift_empty, ser_dat_oe}), 1);
      check_frame(9'h033, 8, 8);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule